// File: doc/BRIEF.md
# SerDes Endpoint Mode and Direction Controller

This block turns the static configuration pins of a bidirectional serializer/deserializer endpoint into its operating state. A two-bit range code selects either power-down (code 00) or one of three active frequency ranges. A direction input selects serializer or deserializer operation, and a multiplier select picks the PLL ratio for the serializer. From these inputs the block produces the enables for the parallel bus and the serial drivers, a global core reset, a PLL enable and the PLL ratio. It also echoes the direction input inverted, so that a far-end device can take its direction from this one.

The block also decides where the serializer takes its bit clock from. After power-up the serializer uses the forwarded bit clock. A monitor runs on a free-running local clock and watches the reference-clock input. Once the monitor has seen the reference clock, the source moves to the reference clock and stays there, even if the reference later stops. Only a power-down, followed by a power-up with the reference held low, brings the source back to the forwarded clock. If the reference is lost, the PLL enable drops, so the PLL can only restart from a valid reference.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: While range code `rng_sel` is 2'b00, at the next clock edge `pwr_down`=1, `core_rst_n`=0, `dir_out_en`=0 and `pll_en`, `par_out_en`, `par_in_en`, `ser_out_en`, `pll_frac_mul` are all 0, whatever `dir_in` and `mult_sel` are; `range_out` reads 2'b00.
- R2: With `rng_sel` at 01, 10 or 11, `dir_in`=1 selects serializer (`par_in_en`=1, `par_out_en`=0) and `dir_in`=0 selects deserializer (`par_out_en`=1, `par_in_en`=0), one clock edge after the inputs; `range_out` then equals `rng_sel`.
- R3: `pll_frac_mul` (1 = 7-1/3x, 0 = 7x) is 1 only in serializer mode with `mult_sel`=0, and is 0 in deserializer mode and in power-down.
- R4: `dir_out` is the inverse of `dir_in` at all times, without a clock; `dir_out_en` is 1 exactly when the block is not powered down.
- R5: `ser_out_en` is 1 only when, at the previous clock edge, the block was in serializer mode and `pll_locked` was 1.
- R6: `ref_present` rises after 4 rising edges of `ref_clk_in` in a row, with each edge less than 64 local clocks after the one before. Fewer edges, or edges spaced wider than that window, leave it at 0.
- R7: `ref_present` falls after 64 local clock cycles with no rising edge on `ref_clk_in`, and `pll_en` falls with it.
- R8: After reset or power-down, `clk_src_ref`=0 (forwarded bit clock). It becomes 1 one clock after `ref_present` rises, and stays 1 after the reference clock stops.
- R9: Only power-down (`rng_sel`=00) or `rst_n` clears `clk_src_ref`. After power-down and power-up with `ref_clk_in` held at 0, it stays 0.
- R10: `pll_en` is 1 one clock after an active range code and `ref_present`=1 are both seen, and is 0 otherwise.
- R11: While `rst_n` is low, the outputs take the power-down state of R1, and `ref_present` and `clk_src_ref` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rng_sel | input | 2 | Range code; 00 is power-down |
| mult_sel | input | 1 | PLL ratio select: 1 = 7x, 0 = 7-1/3x |
| dir_in | input | 1 | 1 = serializer, 0 = deserializer |
| ref_clk_in | input | 1 | Reference clock, sampled by the local clock |
| pll_locked | input | 1 | Lock indication from the PLL |
| dir_out | output | 1 | Inverted direction echo |
| dir_out_en | output | 1 | Drive enable for the direction echo |
| pwr_down | output | 1 | Power-down state |
| core_rst_n | output | 1 | Global core reset, active low |
| pll_en | output | 1 | PLL enable |
| pll_frac_mul | output | 1 | 1 = fractional 7-1/3x ratio |
| range_out | output | 2 | Active range code, 00 when powered down |
| par_out_en | output | 1 | Parallel bus output enable |
| par_in_en | output | 1 | Parallel input buffer enable |
| ser_out_en | output | 1 | Serial driver enable |
| ref_present | output | 1 | Reference clock detected |
| clk_src_ref | output | 1 | 1 = reference clock, 0 = forwarded bit clock |

## Verification
The assertions check on every cycle the parts of the behaviour that are pure decode. These are the inverted direction echo, the forced-off state under range code 00, the mutually exclusive parallel enables, the gating of the serial enable, and the rule that the clock-source latch stays set while power is up. The bench scenarios cover the behaviour that depends on history. They show that three reference edges are not enough and a fourth is, that edges spaced wider than the window never build presence, and that presence is lost after a silent window while the source selection stays put. They also show that the selection returns to the forwarded clock only through a power cycle with the reference held low.

// File: rtl/serdes_ctrl_pkg.sv
// Package: shared types for the SerDes mode controller.
// Assumes: range code 2'b00 means power-down; all other codes are active.
package serdes_ctrl_pkg;

    localparam logic [1:0] RANGE_OFF = 2'b00;

    typedef enum logic [1:0] {
        OPM_OFF = 2'd0,
        OPM_SER = 2'd1,
        OPM_DES = 2'd2
    } op_mode_e;

    typedef struct packed {
        logic pwr_down;
        logic dir_oe;
        logic par_out_en;
        logic par_in_en;
        logic pll_frac;
    } ctrl_bits_t;

endpackage

// File: rtl/mode_decode.sv
// Module: mode_decode
// Combinational decode of range code, direction and multiplier select
// into an operating mode and the static control bits.
// Assumes: the inputs are stable or synchronous to the consuming clock.
module mode_decode
    import serdes_ctrl_pkg::*;
(
    input  logic [1:0] rng_sel,
    input  logic       mult_sel,
    input  logic       dir_in,
    output op_mode_e   mode,
    output ctrl_bits_t bits
);

    // Pick the mode: power-down wins over direction
    always_comb begin
        if (rng_sel == RANGE_OFF) begin
            mode = OPM_OFF;
        end else if (dir_in) begin
            mode = OPM_SER;
        end else begin
            mode = OPM_DES;
        end
    end

    // Derive the enables from the mode
    always_comb begin
        bits.pwr_down   = (mode == OPM_OFF);
        bits.dir_oe     = (mode != OPM_OFF);
        bits.par_out_en = (mode == OPM_DES);
        bits.par_in_en  = (mode == OPM_SER);
        bits.pll_frac   = (mode == OPM_SER) && !mult_sel;
    end

endmodule

// File: rtl/ref_clk_monitor.sv
// Module: ref_clk_monitor
// Samples the reference clock with the local clock and declares it present
// after PRESENT_EDGES rising edges, each within ABSENT_CYCLES of the last.
// It declares it absent after ABSENT_CYCLES with no edge.
// Assumes: the reference runs slower than half the local clock; clear
// forces the monitor back to the absent state.
module ref_clk_monitor #(
    parameter int SYNC_STAGES   = 2,
    parameter int PRESENT_EDGES = 4,
    parameter int ABSENT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref_clk_in,
    output logic ref_present
);

    localparam int EW = (PRESENT_EDGES > 1) ? $clog2(PRESENT_EDGES) : 1;
    localparam int GW = $clog2(ABSENT_CYCLES + 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(PRESENT_EDGES - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(ABSENT_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_seen;
    logic [EW-1:0]          edge_cnt;
    logic [GW-1:0]          gap_cnt;

    // Synchronizer chain for the sampled reference
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            // Shift one stage of the synchronizer
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g] <= ref_clk_in;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    // Hold the last synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_seen = sync_q[SYNC_STAGES-1] && !prev_q;

    // Count edges and silent cycles, and decide presence
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            edge_cnt    <= '0;
            gap_cnt     <= '0;
            ref_present <= 1'b0;
        end else if (edge_seen) begin
            gap_cnt <= '0;
            if (edge_cnt == EDGE_LAST) begin
                ref_present <= 1'b1;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end else if (gap_cnt == GAP_LAST) begin
            gap_cnt     <= '0;
            edge_cnt    <= '0;
            ref_present <= 1'b0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/clk_src_latch.sv
// Module: clk_src_latch
// Sticky selection of the serializer clock source. It starts on the
// forwarded bit clock and moves to the reference clock once the reference
// is present. It returns only on clear (power-down) or reset.
module clk_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref_present,
    output logic use_ref
);

    // Set on presence, hold until power-down
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            use_ref <= 1'b0;
        end else if (ref_present) begin
            use_ref <= 1'b1;
        end
    end

endmodule

// File: rtl/serdes_mode_ctrl.sv
// Module: serdes_mode_ctrl (top)
// Registers the decoded operating state of a bidirectional SerDes endpoint.
// It also drives the PLL enable from reference presence and selects the
// serializer clock source.
// Assumes: clk is free-running and independent of the reference clock;
// the direction echo is a pure inversion, without a clock.
module serdes_mode_ctrl
    import serdes_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int PRESENT_EDGES = 4,
    parameter int ABSENT_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rng_sel,
    input  logic       mult_sel,
    input  logic       dir_in,
    input  logic       ref_clk_in,
    input  logic       pll_locked,
    output logic       dir_out,
    output logic       dir_out_en,
    output logic       pwr_down,
    output logic       core_rst_n,
    output logic       pll_en,
    output logic       pll_frac_mul,
    output logic [1:0] range_out,
    output logic       par_out_en,
    output logic       par_in_en,
    output logic       ser_out_en,
    output logic       ref_present,
    output logic       clk_src_ref
);

    op_mode_e   mode;
    ctrl_bits_t bits;
    logic       pd_req;

    mode_decode u_dec (
        .rng_sel  (rng_sel),
        .mult_sel (mult_sel),
        .dir_in   (dir_in),
        .mode     (mode),
        .bits     (bits)
    );

    assign pd_req = bits.pwr_down;

    ref_clk_monitor #(
        .SYNC_STAGES   (SYNC_STAGES),
        .PRESENT_EDGES (PRESENT_EDGES),
        .ABSENT_CYCLES (ABSENT_CYCLES)
    ) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (pd_req),
        .ref_clk_in  (ref_clk_in),
        .ref_present (ref_present)
    );

    clk_src_latch u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (pd_req),
        .ref_present (ref_present),
        .use_ref     (clk_src_ref)
    );

    // Direction echo is inverted without a clock
    assign dir_out = !dir_in;

    // Register the operating state; reset lands in power-down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_down     <= 1'b1;
            core_rst_n   <= 1'b0;
            dir_out_en   <= 1'b0;
            par_out_en   <= 1'b0;
            par_in_en    <= 1'b0;
            pll_frac_mul <= 1'b0;
            range_out    <= RANGE_OFF;
            ser_out_en   <= 1'b0;
            pll_en       <= 1'b0;
        end else begin
            pwr_down     <= bits.pwr_down;
            core_rst_n   <= !bits.pwr_down;
            dir_out_en   <= bits.dir_oe;
            par_out_en   <= bits.par_out_en;
            par_in_en    <= bits.par_in_en;
            pll_frac_mul <= bits.pll_frac;
            range_out    <= bits.pwr_down ? RANGE_OFF : rng_sel;
            ser_out_en   <= (mode == OPM_SER) && pll_locked;
            pll_en       <= !bits.pwr_down && ref_present;
        end
    end

endmodule

// File: rtl/serdes_mode_ctrl_chk.sv
// Module: serdes_mode_ctrl_chk
// Property checker for serdes_mode_ctrl, attached by bind.
module serdes_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rng_sel,
    input logic       dir_in,
    input logic       pll_locked,
    input logic       dir_out,
    input logic       pwr_down,
    input logic       pll_en,
    input logic       par_out_en,
    input logic       par_in_en,
    input logic       ser_out_en,
    input logic       ref_present,
    input logic       clk_src_ref
);

    // R4
    dir_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out != dir_in);

    // R1
    pd_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_sel == 2'b00) |=> (pwr_down && !pll_en && !par_out_en && !par_in_en && !ser_out_en));

    // R2
    des_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_sel != 2'b00 && !dir_in) |=> (par_out_en && !par_in_en));

    // R5
    ser_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_sel != 2'b00 && dir_in && pll_locked) |=> ser_out_en);

    // R5
    ser_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_en |-> (par_in_en && !pwr_down));

    // R8
    src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src_ref && rng_sel != 2'b00) |=> clk_src_ref);

    // R8
    src_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_src_ref) |-> $past(ref_present));

    // R10
    pll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> !pwr_down);

    // R2
    par_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_out_en && par_in_en));

endmodule

bind serdes_mode_ctrl serdes_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rng_sel     (rng_sel),
    .dir_in      (dir_in),
    .pll_locked  (pll_locked),
    .dir_out     (dir_out),
    .pwr_down    (pwr_down),
    .pll_en      (pll_en),
    .par_out_en  (par_out_en),
    .par_in_en   (par_in_en),
    .ser_out_en  (ser_out_en),
    .ref_present (ref_present),
    .clk_src_ref (clk_src_ref)
);

// File: tb/tb_serdes_mode_ctrl.sv
// Directed bench for serdes_mode_ctrl: one task for each scenario.
module tb_serdes_mode_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rng_sel = 2'b00;
    logic       mult_sel = 1'b1;
    logic       dir_in = 1'b1;
    logic       ref_clk_in = 1'b0;
    logic       pll_locked = 1'b0;
    logic       dir_out, dir_out_en, pwr_down, core_rst_n, pll_en, pll_frac_mul;
    logic [1:0] range_out;
    logic       par_out_en, par_in_en, ser_out_en, ref_present, clk_src_ref;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    serdes_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rng_sel(rng_sel), .mult_sel(mult_sel),
        .dir_in(dir_in), .ref_clk_in(ref_clk_in), .pll_locked(pll_locked),
        .dir_out(dir_out), .dir_out_en(dir_out_en), .pwr_down(pwr_down),
        .core_rst_n(core_rst_n), .pll_en(pll_en), .pll_frac_mul(pll_frac_mul),
        .range_out(range_out), .par_out_en(par_out_en), .par_in_en(par_in_en),
        .ser_out_en(ser_out_en), .ref_present(ref_present), .clk_src_ref(clk_src_ref)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Apply inputs away from the edge, then sample just after the next edge
    task automatic apply(input logic [1:0] r, input logic d, input logic m, input logic l);
        @(negedge clk);
        rng_sel = r; dir_in = d; mult_sel = m; pll_locked = l;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ref_pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_clk_in = 1'b1;
            idle(half);
            ref_clk_in = 1'b0;
            idle(half);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(2'b01, 1'b1, 1'b1, 1'b1);
        chk("R11", "pwr_down", int'(pwr_down), 1);
        chk("R11", "core_rst_n", int'(core_rst_n), 0);
        chk("R11", "ser_out_en", int'(ser_out_en), 0);
        chk("R11", "clk_src_ref", int'(clk_src_ref), 0);
        chk("R11", "ref_present", int'(ref_present), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_powerdown;
        apply(2'b00, 1'b0, 1'b0, 1'b1);
        chk("R1", "pwr_down", int'(pwr_down), 1);
        chk("R1", "par_out_en", int'(par_out_en), 0);
        chk("R1", "pll_frac_mul", int'(pll_frac_mul), 0);
        chk("R1", "dir_out_en", int'(dir_out_en), 0);
        chk("R1", "range_out", int'(range_out), 0);
        chk("R4", "dir_out in power-down", int'(dir_out), 1);
    endtask

    task automatic t_modes;
        apply(2'b10, 1'b1, 1'b1, 1'b0);
        chk("R2", "ser par_in_en", int'(par_in_en), 1);
        chk("R2", "ser par_out_en", int'(par_out_en), 0);
        chk("R2", "range_out", int'(range_out), 2);
        chk("R4", "dir_out ser", int'(dir_out), 0);
        chk("R4", "dir_out_en", int'(dir_out_en), 1);
        chk("R3", "7x ratio", int'(pll_frac_mul), 0);
        apply(2'b11, 1'b1, 1'b0, 1'b0);
        chk("R3", "fractional ratio", int'(pll_frac_mul), 1);
        chk("R5", "ser_out_en unlocked", int'(ser_out_en), 0);
        apply(2'b11, 1'b1, 1'b0, 1'b1);
        chk("R5", "ser_out_en locked", int'(ser_out_en), 1);
        apply(2'b01, 1'b0, 1'b0, 1'b1);
        chk("R2", "des par_out_en", int'(par_out_en), 1);
        chk("R2", "des par_in_en", int'(par_in_en), 0);
        chk("R3", "no ratio in des", int'(pll_frac_mul), 0);
        chk("R5", "ser_out_en in des", int'(ser_out_en), 0);
        chk("R4", "dir_out des", int'(dir_out), 1);
        chk("R10", "pll_en without ref", int'(pll_en), 0);
    endtask

    task automatic t_ref_detect;
        apply(2'b01, 1'b1, 1'b1, 1'b1);
        ref_pulses(3, 4);
        chk("R6", "present after 3 edges", int'(ref_present), 0);
        chk("R8", "source before detect", int'(clk_src_ref), 0);
        ref_pulses(1, 4);
        chk("R6", "present after 4 edges", int'(ref_present), 1);
        chk("R8", "source after detect", int'(clk_src_ref), 1);
        chk("R10", "pll_en with ref", int'(pll_en), 1);
        idle(80);
        chk("R7", "present after silence", int'(ref_present), 0);
        chk("R7", "pll_en after loss", int'(pll_en), 0);
        chk("R8", "source sticky after loss", int'(clk_src_ref), 1);
    endtask

    task automatic t_power_cycle;
        apply(2'b00, 1'b1, 1'b1, 1'b1);
        chk("R9", "source cleared by power-down", int'(clk_src_ref), 0);
        apply(2'b11, 1'b1, 1'b1, 1'b1);
        idle(20);
        chk("R9", "source stays forwarded", int'(clk_src_ref), 0);
        ref_pulses(5, 40);
        chk("R6", "slow edges never present", int'(ref_present), 0);
        chk("R9", "source after slow edges", int'(clk_src_ref), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_powerdown();
        t_modes();
        t_ref_detect();
        t_power_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule